// File: doc/BRIEF.md
# Sensor-Triggered Traffic Light Sequencer

This block runs the lamps at a junction of a main highway and a farm road. Each road has a three-bit lamp vector. The encoding is bit 2 = red, bit 1 = amber and bit 0 = green. While the block rests, the highway shows green and the farm road shows red.

A farm-road vehicle sensor starts a timed cycle. A tick counter then runs from 1 up to a fixed last value (53 by default) on every clock edge, whatever the sensor does. The lamp vectors are decoded from the tick value:

- highway amber first;
- then highway red and farm green from tick 13;
- then farm amber from tick 43.

When the counter wraps from its last value back to 0, the junction returns to rest.

The block has no streaming data path. All pins are plain control and status signals, so no valid/ready handshake and no back-pressure apply. An active-low asynchronous reset forces the rest state at once.

Top module: `traffic_seq`

## Requirements
- R1: While `rst_n` is low, the block shows `hwy_lamp` = 3'b001 (green) and `farm_lamp` = 3'b100 (red), with `tick` = 0 and `busy` = 0. The lamp encoding is bit 2 red, bit 1 amber, bit 0 green.
- R2: At rest, a clock edge with `farm_sense` = 0 leaves `tick` at 0, `busy` at 0 and the rest lamps unchanged.
- R3: At rest, a clock edge with `farm_sense` = 1 sets `tick` to 1 and `busy` to 1. For ticks 1 to 12, `hwy_lamp` is 3'b010 (amber) and `farm_lamp` is 3'b100 (red).
- R4: While `busy` is 1 and `tick` is below 53, every clock edge adds 1 to `tick`, whatever the value of `farm_sense`.
- R5: For ticks 13 to 42 while busy, `hwy_lamp` is 3'b100 (red) and `farm_lamp` is 3'b001 (green).
- R6: For ticks 43 to 53 while busy, `hwy_lamp` is 3'b100 (red) and `farm_lamp` is 3'b010 (amber).
- R7: The edge taken at tick 53 returns `tick` to 0, `busy` to 0 and the lamps to the rest state, even if `farm_sense` is 1 on that edge. A new cycle can begin on the following edge.
- R8: Each lamp vector has exactly one bit set at all times, and at least one road shows red.
- R9: Pulling `rst_n` low in the middle of a cycle forces the rest state of R1 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| farm_sense | input | 1 | Farm-road vehicle sensor; starts a cycle while at rest |
| hwy_lamp | output | 3 | Highway lamps: bit 2 red, bit 1 amber, bit 0 green |
| farm_lamp | output | 3 | Farm-road lamps: bit 2 red, bit 1 amber, bit 0 green |
| tick | output | TICK_W (6) | Current tick of the cycle; 0 at rest |
| busy | output | 1 | High from the starting edge until the wrap back to 0 |

## Verification
`tick` and `busy` respond one rising edge after the sensor value sampled on that edge. The lamp vectors are decoded combinationally from those registers, so they change in the same cycle as the count. Reset takes effect with no edge at all. The bench changes `farm_sense` on a falling edge and lets one rising edge pass. It then compares all outputs on the next falling edge against a model that it advanced for that same edge. The mid-cycle reset is checked one time unit after `rst_n` falls, with no clock edge in between.

// File: rtl/traffic_seq_pkg.sv
package traffic_seq_pkg;
  // lamp encoding: bit 2 red, bit 1 amber, bit 0 green
  localparam logic [2:0] LAMP_RED   = 3'b100;
  localparam logic [2:0] LAMP_AMBER = 3'b010;
  localparam logic [2:0] LAMP_GREEN = 3'b001;

  typedef enum logic [1:0] {
    PH_REST      = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;
endpackage

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
  parameter int LAST = 53,
  parameter int W    = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_req,
  output logic [W-1:0] cnt,
  output logic         run
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (run) begin
      if (cnt == LAST_V) begin
        cnt <= '0;
        run <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start_req) begin
      cnt <= {{(W-1){1'b0}}, 1'b1};
      run <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_phase_decode.sv
module seq_phase_decode
  import traffic_seq_pkg::*;
#(
  parameter int W        = 6,
  parameter int GO_TICK  = 13,
  parameter int WARN_TICK = 43
) (
  input  logic [W-1:0] cnt,
  input  logic         run,
  output phase_e       phase
);
  localparam logic [W-1:0] GO_V   = W'(GO_TICK);
  localparam logic [W-1:0] WARN_V = W'(WARN_TICK);

  always_comb begin
    if (!run)              phase = PH_REST;
    else if (cnt < GO_V)   phase = PH_HWY_WARN;
    else if (cnt < WARN_V) phase = PH_FARM_GO;
    else                   phase = PH_FARM_WARN;
  end
endmodule

// File: rtl/seq_lamp_map.sv
module seq_lamp_map
  import traffic_seq_pkg::*;
(
  input  phase_e     phase,
  output logic [2:0] hwy,
  output logic [2:0] farm
);
  always_comb begin
    unique case (phase)
      PH_REST:      begin hwy = LAMP_GREEN; farm = LAMP_RED;   end
      PH_HWY_WARN:  begin hwy = LAMP_AMBER; farm = LAMP_RED;   end
      PH_FARM_GO:   begin hwy = LAMP_RED;   farm = LAMP_GREEN; end
      PH_FARM_WARN: begin hwy = LAMP_RED;   farm = LAMP_AMBER; end
      default:      begin hwy = LAMP_RED;   farm = LAMP_RED;   end
    endcase
  end
endmodule

// File: rtl/traffic_seq.sv
module traffic_seq
  import traffic_seq_pkg::*;
#(
  parameter int CYCLE_LAST     = 53,
  parameter int FARM_GO_TICK   = 13,
  parameter int FARM_WARN_TICK = 43,
  localparam int TICK_W        = $clog2(CYCLE_LAST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              farm_sense,
  output logic [2:0]        hwy_lamp,
  output logic [2:0]        farm_lamp,
  output logic [TICK_W-1:0] tick,
  output logic              busy
);
  phase_e phase;

  seq_tick_counter #(.LAST(CYCLE_LAST), .W(TICK_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (farm_sense),
    .cnt       (tick),
    .run       (busy)
  );

  seq_phase_decode #(.W(TICK_W), .GO_TICK(FARM_GO_TICK), .WARN_TICK(FARM_WARN_TICK)) dec_i (
    .cnt   (tick),
    .run   (busy),
    .phase (phase)
  );

  seq_lamp_map map_i (
    .phase (phase),
    .hwy   (hwy_lamp),
    .farm  (farm_lamp)
  );
endmodule

// File: rtl/traffic_seq_chk.sv
module traffic_seq_chk #(
  parameter int CYCLE_LAST     = 53,
  parameter int FARM_GO_TICK   = 13,
  parameter int FARM_WARN_TICK = 43,
  parameter int TICK_W         = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              farm_sense,
  input logic [2:0]        hwy_lamp,
  input logic [2:0]        farm_lamp,
  input logic [TICK_W-1:0] tick,
  input logic              busy
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (tick == '0 && !busy && hwy_lamp == 3'b001 && farm_lamp == 3'b100));

  a_r2_rest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !farm_sense) |=> (!busy && tick == '0));

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && farm_sense) |=> (busy && int'(tick) == 1));

  a_r3_hwy_amber: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(tick) < FARM_GO_TICK) |-> (hwy_lamp == 3'b010 && farm_lamp == 3'b100));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(tick) != CYCLE_LAST) |=> (busy && tick == $past(tick) + 1'b1));

  a_r5_farm_go: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(tick) >= FARM_GO_TICK && int'(tick) < FARM_WARN_TICK)
      |-> (hwy_lamp == 3'b100 && farm_lamp == 3'b001));

  a_r6_farm_warn: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(tick) >= FARM_WARN_TICK) |-> (hwy_lamp == 3'b100 && farm_lamp == 3'b010));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(tick) == CYCLE_LAST) |=> (!busy && tick == '0));

  a_r8_one_lamp: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(hwy_lamp) == 1 && $countones(farm_lamp) == 1));

  a_r8_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_lamp[2] || farm_lamp[2]));
endmodule

bind traffic_seq traffic_seq_chk #(
  .CYCLE_LAST(CYCLE_LAST), .FARM_GO_TICK(FARM_GO_TICK),
  .FARM_WARN_TICK(FARM_WARN_TICK), .TICK_W(TICK_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .farm_sense(farm_sense), .hwy_lamp(hwy_lamp),
  .farm_lamp(farm_lamp), .tick(tick), .busy(busy)
);

// File: tb/traffic_seq_tb_top.sv
module traffic_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAST = 53;
  localparam int GO   = 13;
  localparam int WARN = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic farm_sense = 1'b0;
  logic [2:0] hwy_lamp, farm_lamp;
  logic [5:0] tick;
  logic busy;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt = 0;
  bit m_busy = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  traffic_seq dut_i (
    .clk(clk), .rst_n(rst_n), .farm_sense(farm_sense),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp), .tick(tick), .busy(busy)
  );

  function automatic logic [2:0] exp_hwy(int c, bit b);
    if (!b)     return 3'b001;
    if (c < GO) return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [2:0] exp_farm(int c, bit b);
    if (!b || c < GO) return 3'b100;
    if (c < WARN)     return 3'b001;
    return 3'b010;
  endfunction

  function automatic string req_of(int c, bit b);
    if (!b)      return "R2/R7";
    if (c < GO)  return "R3";
    if (c < WARN) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "tick", int'(tick), m_cnt);
    check(req, "busy", int'(busy), int'(m_busy));
    check(req, "hwy_lamp", int'(hwy_lamp), int'(exp_hwy(m_cnt, m_busy)));
    check(req, "farm_lamp", int'(farm_lamp), int'(exp_farm(m_cnt, m_busy)));
    // R8: one lamp per road, at least one red
    check("R8", "onehot_and_red",
          int'($countones(hwy_lamp) == 1 && $countones(farm_lamp) == 1 &&
               (hwy_lamp[2] || farm_lamp[2])), 1);
  endtask

  // called right after a falling edge: drive, take one rising edge, check
  task automatic step(bit s);
    farm_sense = s;
    @(posedge clk);
    if (m_busy) begin
      if (m_cnt == LAST) begin m_cnt = 0; m_busy = 1'b0; end
      else m_cnt = m_cnt + 1;
    end else if (s) begin
      m_cnt = 1; m_busy = 1'b1;
    end
    @(negedge clk);
    check_all(req_of(m_cnt, m_busy));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    #1;
    // R1: reset state
    check_all("R1");
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;

    // R2: stay at rest with sensor low
    for (int i = 0; i < 5; i++) step(1'b0);

    // R3/R4: one-cycle sensor pulse, then the cycle runs with the sensor low
    step(1'b1);
    check("R3", "start_tick", int'(tick), 1);
    while (m_busy) step(1'b0);
    check("R7", "wrap_rest_busy", int'(busy), 0);

    // R4/R7: sensor held high through a whole cycle and its wrap
    step(1'b1);
    while (m_busy) step(1'b1);
    check("R7", "wrap_ignores_sensor", int'(tick), 0);
    step(1'b1);
    check("R7", "restart_next_edge", int'(busy), 1);

    // random sensor traffic
    for (int i = 0; i < 400; i++) step(($urandom % 5) == 0);

    // R9: asynchronous reset in the middle of a cycle
    while (!m_busy) step(1'b1);
    for (int i = 0; i < 20; i++) step(1'b0);
    #1;
    rst_n = 1'b0;
    #1;
    m_cnt = 0;
    m_busy = 1'b0;
    check_all("R9");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    step(1'b1);
    check("R9", "start_after_reset", int'(tick), 1);

    finish_up();
  end
endmodule